// File: doc/BRIEF.md
# Interrupt presentation controller

This block is the per-processor end of an interrupt fabric. It holds the processor's current priority threshold, a software-programmed inter-processor interrupt (IPI) request priority, the number of the one source currently pending, and that source's priority. Interrupt sources offer deliveries to it. The processor drives it through four operations: accept, set threshold, set IPI priority and end-of-interrupt. A single level output tells the processor that a pending interrupt beats its threshold.

Priorities are 8 bits wide, and a lower value is more favored. A pending priority of 0xFF means that no interrupt is pending. Source number 0 means no source. Source number `IPI_SRC` (default 2) is reserved for the IPI.

An offer that wins displaces the source that was pending. The displaced source is reported back as rejected, so the fabric can route it again. An offer that loses sets a sticky need-resend flag. That flag is released as a one-cycle resend request, but only when the threshold is relaxed or the IPI priority is made less favored. Processor operations take precedence over offers, and at most one operation is applied per cycle.

Top module: `irq_present_unit`

## Requirements
- R1: After reset the threshold is 0x00, the IPI priority is 0xFF, the pending priority is 0xFF, the pending source is 0 and need-resend is 0. At reset `acc_word_o` reads 0, `irq_o` is low, `offer_ready_o` is high, and `reject_valid_o`, `resend_o` and `eoi_valid_o` are low.
- R2: `irq_o` is high exactly when the pending source is nonzero and the pending priority is strictly below the threshold. It is a level derived from state, so it reflects each update from the cycle after that update.
- R3: An offer of priority p, taken while `offer_ready_o` is high, wins only if the threshold, the IPI priority and the pending priority all exceed p strictly. `offer_ok_o` shows the win combinationally in the same cycle. On a win, the offered source and p become pending, and the displaced source is a reject candidate.
- R4: `offer_ready_o` is low in any cycle with `op_valid_i` high, and an offer in such a cycle has no effect. A losing offer sets need-resend.
- R5: Accept (`op_kind_i`=0) is applied when `op_valid_i` is high. During the op cycle, `acc_word_o` shows the threshold in bits 31:24 and the pending source in bits 23:0. If the pending source is nonzero, the op sets the threshold to the pending priority, the pending priority to 0xFF and the pending source to 0. If the pending source is zero, the op changes nothing.
- R6: Set IPI priority (`op_kind_i`=2, value m in `op_data_i[7:0]`) always stores m. If m is below the threshold and m is no greater than the pending priority, the pending source becomes a reject candidate, the pending priority becomes m and the pending source becomes `IPI_SRC`.
- R7: When a set-IPI-priority op raises the stored value numerically, `resend_o` pulses in the next cycle with the old need-resend value, and need-resend is cleared.
- R8: Set threshold (`op_kind_i`=1, value c in `op_data_i[7:0]`) with c greater than the threshold runs the relax sequence:
  - The threshold becomes c.
  - If the IPI priority is below c and no greater than the pending priority, the IPI becomes pending. This step raises no reject.
  - `resend_o` carries the old need-resend value, and need-resend is cleared.
  A value equal to the current threshold changes nothing.
- R9: Set threshold with c below the current threshold loads c. If c is no greater than the pending priority, the pending source becomes a reject candidate, the pending source becomes 0 and the pending priority becomes 0xFF.
- R10: End-of-interrupt (`op_kind_i`=3) applies the relax sequence of R8 unconditionally with `op_data_i[31:24]`. Next cycle `eoi_valid_o` pulses with `eoi_src_o`=`op_data_i[23:0]`, except when that source equals `IPI_SRC`.
- R11: A reject candidate is reported by a one-cycle pulse on `reject_valid_o` in the next cycle, with its number on `reject_src_o`. A candidate equal to 0 or to `IPI_SRC` is not reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Processor operation valid |
| op_kind_i | input | 2 | 0 accept, 1 set threshold, 2 set IPI priority, 3 end-of-interrupt |
| op_data_i | input | 32 | Operation operand |
| acc_word_o | output | 32 | Threshold in bits 31:24 and pending source in bits 23:0 |
| offer_valid_i | input | 1 | Delivery offer valid |
| offer_src_i | input | 24 | Offered source number |
| offer_prio_i | input | 8 | Offered priority |
| offer_ready_o | output | 1 | Offer is evaluated this cycle |
| offer_ok_o | output | 1 | Offer wins this cycle |
| irq_o | output | 1 | Interrupt request to the processor |
| reject_valid_o | output | 1 | Displaced source report |
| reject_src_o | output | 24 | Displaced source number |
| resend_o | output | 1 | Resend request pulse |
| eoi_valid_o | output | 1 | Acknowledge forwarded to sources |
| eoi_src_o | output | 24 | Acknowledged source number |

## Verification
The bench builds the block with the default 8-bit priorities, 24-bit source numbers and an IPI source number of 2. This makes the IPI filtering on both the reject and the acknowledge paths reachable from directed writes of source 2. The random stimulus draws priorities from 0..7 plus 0xFF. Ties between the offered priority, the threshold, the IPI priority and the pending priority are therefore frequent, so the strict-versus-inclusive comparisons in every rule are exercised many times over.

// File: rtl/ipu_pkg.sv
package ipu_pkg;
  localparam int PRIO_W = 8;
  localparam int SRC_W  = 24;
  localparam int WORD_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

  typedef enum logic [1:0] {
    OP_ACCEPT   = 2'd0,
    OP_SET_CPPR = 2'd1,
    OP_SET_MFRR = 2'd2,
    OP_EOI      = 2'd3
  } ipu_op_e;

  typedef struct packed {
    logic [PRIO_W-1:0] cppr;
    logic [PRIO_W-1:0] mfrr;
    logic [PRIO_W-1:0] pend;
    logic [SRC_W-1:0]  xisr;
    logic              need;
  } ipu_state_t;

  localparam ipu_state_t RESET_STATE = '{cppr: '0, mfrr: PRIO_NONE,
                                         pend: PRIO_NONE, xisr: '0, need: 1'b0};

  // relax sequence: load threshold, maybe raise IPI, release resend flag
  function automatic ipu_state_t relax_cppr(ipu_state_t s, logic [PRIO_W-1:0] c,
                                            logic [SRC_W-1:0] ipi);
    ipu_state_t n;
    n = s;
    n.cppr = c;
    if (s.mfrr < c && s.mfrr <= s.pend) begin
      n.pend = s.mfrr;
      n.xisr = ipi;
    end
    n.need = 1'b0;
    return n;
  endfunction
endpackage

// File: rtl/ipu_offer_gate.sv
module ipu_offer_gate
  import ipu_pkg::*;
(
  input  logic [PRIO_W-1:0] cppr_i,
  input  logic [PRIO_W-1:0] mfrr_i,
  input  logic [PRIO_W-1:0] pend_i,
  input  logic [PRIO_W-1:0] prio_i,
  output logic              win_o
);
  always_comb win_o = (cppr_i > prio_i) && (mfrr_i > prio_i) && (pend_i > prio_i);
endmodule

// File: rtl/ipu_op_engine.sv
module ipu_op_engine
  import ipu_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_SRC = 24'd2
) (
  input  ipu_state_t         st_i,
  input  logic               op_valid_i,
  input  ipu_op_e            op_kind_i,
  input  logic [WORD_W-1:0]  op_data_i,
  input  logic               offer_valid_i,
  input  logic [SRC_W-1:0]   offer_src_i,
  input  logic [PRIO_W-1:0]  offer_prio_i,
  input  logic               offer_win_i,
  output ipu_state_t         st_o,
  output logic               rej_o,
  output logic [SRC_W-1:0]   rej_src_o,
  output logic               rsnd_o,
  output logic               ack_o,
  output logic [SRC_W-1:0]   ack_src_o
);
  logic [PRIO_W-1:0] val;
  logic [PRIO_W-1:0] hi_val;

  assign val    = op_data_i[PRIO_W-1:0];
  assign hi_val = op_data_i[WORD_W-1:SRC_W];

  always_comb begin
    st_o      = st_i;
    rej_o     = 1'b0;
    rej_src_o = '0;
    rsnd_o    = 1'b0;
    ack_o     = 1'b0;
    ack_src_o = '0;
    if (op_valid_i) begin
      unique case (op_kind_i)
        OP_ACCEPT: begin
          if (st_i.xisr != '0) begin
            st_o.cppr = st_i.pend;
            st_o.pend = PRIO_NONE;
            st_o.xisr = '0;
          end
        end
        OP_SET_CPPR: begin
          if (val > st_i.cppr) begin
            st_o   = relax_cppr(st_i, val, IPI_SRC);
            rsnd_o = st_i.need;
          end else if (val < st_i.cppr) begin
            st_o.cppr = val;
            if (val <= st_i.pend) begin
              rej_o     = 1'b1;
              rej_src_o = st_i.xisr;
              st_o.xisr = '0;
              st_o.pend = PRIO_NONE;
            end
          end
        end
        OP_SET_MFRR: begin
          st_o.mfrr = val;
          if (val < st_i.cppr && val <= st_i.pend) begin
            rej_o     = 1'b1;
            rej_src_o = st_i.xisr;
            st_o.pend = val;
            st_o.xisr = IPI_SRC;
          end
          if (val > st_i.mfrr) begin
            rsnd_o    = st_i.need;
            st_o.need = 1'b0;
          end
        end
        OP_EOI: begin
          st_o      = relax_cppr(st_i, hi_val, IPI_SRC);
          rsnd_o    = st_i.need;
          ack_o     = 1'b1;
          ack_src_o = op_data_i[SRC_W-1:0];
        end
        default: ;
      endcase
    end else if (offer_valid_i) begin
      if (offer_win_i) begin
        rej_o     = 1'b1;
        rej_src_o = st_i.xisr;
        st_o.xisr = offer_src_i;
        st_o.pend = offer_prio_i;
      end else begin
        st_o.need = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ipu_event_regs.sv
module ipu_event_regs
  import ipu_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_SRC = 24'd2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rej_i,
  input  logic [SRC_W-1:0] rej_src_i,
  input  logic             rsnd_i,
  input  logic             ack_i,
  input  logic [SRC_W-1:0] ack_src_i,
  output logic             rej_valid_o,
  output logic [SRC_W-1:0] rej_src_o,
  output logic             rsnd_o,
  output logic             ack_valid_o,
  output logic [SRC_W-1:0] ack_src_o
);
  logic rej_keep, ack_keep;

  // no source and the IPI never travel back to the sources
  assign rej_keep = rej_i && (rej_src_i != '0) && (rej_src_i != IPI_SRC);
  assign ack_keep = ack_i && (ack_src_i != IPI_SRC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rej_valid_o <= 1'b0;
      rej_src_o   <= '0;
      rsnd_o      <= 1'b0;
      ack_valid_o <= 1'b0;
      ack_src_o   <= '0;
    end else begin
      rej_valid_o <= rej_keep;
      rej_src_o   <= rej_keep ? rej_src_i : '0;
      rsnd_o      <= rsnd_i;
      ack_valid_o <= ack_keep;
      ack_src_o   <= ack_keep ? ack_src_i : '0;
    end
  end
endmodule

// File: rtl/irq_present_unit.sv
module irq_present_unit
  import ipu_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_SRC = 24'd2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [1:0]        op_kind_i,
  input  logic [WORD_W-1:0] op_data_i,
  output logic [WORD_W-1:0] acc_word_o,
  input  logic              offer_valid_i,
  input  logic [SRC_W-1:0]  offer_src_i,
  input  logic [PRIO_W-1:0] offer_prio_i,
  output logic              offer_ready_o,
  output logic              offer_ok_o,
  output logic              irq_o,
  output logic              reject_valid_o,
  output logic [SRC_W-1:0]  reject_src_o,
  output logic              resend_o,
  output logic              eoi_valid_o,
  output logic [SRC_W-1:0]  eoi_src_o
);
  ipu_state_t       st_q, st_d;
  logic             win;
  logic             rej, rsnd, ack;
  logic [SRC_W-1:0] rej_src, ack_src;

  ipu_offer_gate u_gate (
    .cppr_i (st_q.cppr),
    .mfrr_i (st_q.mfrr),
    .pend_i (st_q.pend),
    .prio_i (offer_prio_i),
    .win_o  (win)
  );

  ipu_op_engine #(.IPI_SRC(IPI_SRC)) u_engine (
    .st_i          (st_q),
    .op_valid_i    (op_valid_i),
    .op_kind_i     (ipu_op_e'(op_kind_i)),
    .op_data_i     (op_data_i),
    .offer_valid_i (offer_valid_i),
    .offer_src_i   (offer_src_i),
    .offer_prio_i  (offer_prio_i),
    .offer_win_i   (win),
    .st_o          (st_d),
    .rej_o         (rej),
    .rej_src_o     (rej_src),
    .rsnd_o        (rsnd),
    .ack_o         (ack),
    .ack_src_o     (ack_src)
  );

  ipu_event_regs #(.IPI_SRC(IPI_SRC)) u_events (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rej_i       (rej),
    .rej_src_i   (rej_src),
    .rsnd_i      (rsnd),
    .ack_i       (ack),
    .ack_src_i   (ack_src),
    .rej_valid_o (reject_valid_o),
    .rej_src_o   (reject_src_o),
    .rsnd_o      (resend_o),
    .ack_valid_o (eoi_valid_o),
    .ack_src_o   (eoi_src_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= RESET_STATE;
    else         st_q <= st_d;
  end

  assign acc_word_o    = {st_q.cppr, st_q.xisr};
  assign offer_ready_o = !op_valid_i;
  assign offer_ok_o    = offer_valid_i && !op_valid_i && win;
  assign irq_o         = (st_q.xisr != '0) && (st_q.pend < st_q.cppr);
endmodule

// File: rtl/irq_present_unit_chk.sv
module irq_present_unit_chk
  import ipu_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_SRC = 24'd2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_valid_i,
  input logic [1:0]        op_kind_i,
  input logic              offer_valid_i,
  input logic [SRC_W-1:0]  offer_src_i,
  input logic [PRIO_W-1:0] offer_prio_i,
  input logic              offer_ready_o,
  input logic              offer_ok_o,
  input logic              irq_o,
  input logic              reject_valid_o,
  input logic [SRC_W-1:0]  reject_src_o,
  input logic              eoi_valid_o,
  input logic [SRC_W-1:0]  eoi_src_o,
  input logic [PRIO_W-1:0] cppr_q,
  input logic [PRIO_W-1:0] pend_q,
  input logic [SRC_W-1:0]  xisr_q,
  input logic              need_q
);
  AST_OP_BLOCKS_OFFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i |-> !offer_ready_o); // R4
  AST_REFUSE_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (offer_valid_i && offer_ready_o && !offer_ok_o) |=> need_q); // R4
  AST_OFFER_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    offer_ok_o |=> (xisr_q == $past(offer_src_i)) && (pend_q == $past(offer_prio_i))); // R3
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (xisr_q != '0) && (pend_q != PRIO_NONE)); // R2
  AST_ACCEPT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_kind_i == 2'd0 && xisr_q == '0) |=> $stable(cppr_q) && $stable(pend_q)); // R5
  AST_REJECT_FILTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_valid_o |-> (reject_src_o != '0) && (reject_src_o != IPI_SRC)); // R11
  AST_EOI_FILTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_valid_o |-> (eoi_src_o != IPI_SRC)); // R10
endmodule

bind irq_present_unit irq_present_unit_chk #(.IPI_SRC(IPI_SRC)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .op_valid_i     (op_valid_i),
  .op_kind_i      (op_kind_i),
  .offer_valid_i  (offer_valid_i),
  .offer_src_i    (offer_src_i),
  .offer_prio_i   (offer_prio_i),
  .offer_ready_o  (offer_ready_o),
  .offer_ok_o     (offer_ok_o),
  .irq_o          (irq_o),
  .reject_valid_o (reject_valid_o),
  .reject_src_o   (reject_src_o),
  .eoi_valid_o    (eoi_valid_o),
  .eoi_src_o      (eoi_src_o),
  .cppr_q         (st_q.cppr),
  .pend_q         (st_q.pend),
  .xisr_q         (st_q.xisr),
  .need_q         (st_q.need)
);

// File: tb/irq_present_unit_tb.sv
module irq_present_unit_tb;
  localparam logic [23:0] IPI = 24'd2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_kind = '0;
  logic [31:0] op_data = '0;
  logic        offer_valid = 1'b0;
  logic [23:0] offer_src = '0;
  logic [7:0]  offer_prio = '0;
  logic [31:0] acc_word;
  logic        offer_ready, offer_ok, irq;
  logic        rej_v, rsnd, eoi_v;
  logic [23:0] rej_s, eoi_s;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // reference state
  logic [7:0]  m_cppr, m_mfrr, m_pend;
  logic [23:0] m_xisr;
  bit          m_need;

  always #2 clk = ~clk;

  irq_present_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .op_valid_i(op_valid), .op_kind_i(op_kind), .op_data_i(op_data),
    .acc_word_o(acc_word),
    .offer_valid_i(offer_valid), .offer_src_i(offer_src), .offer_prio_i(offer_prio),
    .offer_ready_o(offer_ready), .offer_ok_o(offer_ok), .irq_o(irq),
    .reject_valid_o(rej_v), .reject_src_o(rej_s), .resend_o(rsnd),
    .eoi_valid_o(eoi_v), .eoi_src_o(eoi_s)
  );

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic relax(input logic [7:0] c);
    m_cppr = c;
    if (m_mfrr < c && m_mfrr <= m_pend) begin
      m_pend = m_mfrr;
      m_xisr = IPI;
    end
    m_need = 1'b0;
  endtask

  task automatic step(input string tag, input bit opv, input logic [1:0] k,
                      input logic [31:0] d, input bit ofv, input logic [23:0] os,
                      input logic [7:0] op);
    bit          e_rej, e_rs, e_ack, ok;
    logic [23:0] e_rej_s, e_ack_s;
    logic [7:0]  v;
    e_rej = 0; e_rs = 0; e_ack = 0; e_rej_s = '0; e_ack_s = '0;
    v = d[7:0];
    @(negedge clk);
    op_valid = opv; op_kind = k; op_data = d;
    offer_valid = ofv; offer_src = os; offer_prio = op;
    #1;
    ok = ofv && !opv && (m_cppr > op) && (m_mfrr > op) && (m_pend > op);
    chk({tag, " R4 offer_ready"}, 64'(offer_ready), 64'(!opv));
    chk({tag, " R3 offer_ok"}, 64'(offer_ok), 64'(ok));
    if (opv && k == 2'd0) chk({tag, " R5 accept word"}, 64'(acc_word), 64'({m_cppr, m_xisr}));
    if (opv) begin
      case (k)
        2'd0: if (m_xisr != 0) begin m_cppr = m_pend; m_pend = 8'hFF; m_xisr = 0; end
        2'd1: begin
          if (v > m_cppr) begin e_rs = m_need; relax(v); end
          else if (v < m_cppr) begin
            m_cppr = v;
            if (v <= m_pend) begin e_rej = 1; e_rej_s = m_xisr; m_xisr = 0; m_pend = 8'hFF; end
          end
        end
        2'd2: begin
          if (v < m_cppr && v <= m_pend) begin e_rej = 1; e_rej_s = m_xisr; m_pend = v; m_xisr = IPI; end
          if (v > m_mfrr) begin e_rs = m_need; m_need = 0; end
          m_mfrr = v;
        end
        default: begin
          e_rs = m_need; relax(d[31:24]);
          e_ack = (d[23:0] != IPI); e_ack_s = e_ack ? d[23:0] : '0;
        end
      endcase
    end else if (ofv) begin
      if (ok) begin e_rej = 1; e_rej_s = m_xisr; m_xisr = os; m_pend = op; end
      else m_need = 1;
    end
    if (e_rej && (e_rej_s == 0 || e_rej_s == IPI)) begin e_rej = 0; e_rej_s = '0; end
    @(posedge clk); #1;
    op_valid = 0; offer_valid = 0;
    chk({tag, " R8 state word"}, 64'(acc_word), 64'({m_cppr, m_xisr}));
    chk({tag, " R2 irq"}, 64'(irq), 64'((m_xisr != 0) && (m_pend < m_cppr)));
    chk({tag, " R11 reject_valid"}, 64'(rej_v), 64'(e_rej));
    chk({tag, " R11 reject_src"}, 64'(rej_s), 64'(e_rej_s));
    chk({tag, " R7 resend"}, 64'(rsnd), 64'(e_rs));
    chk({tag, " R10 eoi_valid"}, 64'(eoi_v), 64'(e_ack));
    chk({tag, " R10 eoi_src"}, 64'(eoi_s), 64'(e_ack_s));
  endtask

  function automatic logic [7:0] rnd_prio();
    return ($urandom % 10 == 9) ? 8'hFF : 8'($urandom % 8);
  endfunction

  initial begin
    void'($urandom(32'd4711));
    m_cppr = 8'h00; m_mfrr = 8'hFF; m_pend = 8'hFF; m_xisr = '0; m_need = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 reset word", 64'(acc_word), 64'(0));
    chk("R1 reset irq", 64'(irq), 64'(0));
    chk("R1 reset ready", 64'(offer_ready), 64'(1));
    chk("R1 reset pulses", 64'({rej_v, rsnd, eoi_v}), 64'(0));
    @(negedge clk); rst_n = 1'b1;

    step("R4 refused at threshold 0", 0, 0, 0, 1, 24'h55, 8'd3);
    step("R8 relax releases resend", 1, 2'd1, 32'hFF, 0, 0, 0);
    step("R3 first win", 0, 0, 0, 1, 24'h55, 8'd5);
    step("R4 equal priority refused", 0, 0, 0, 1, 24'h66, 8'd5);
    step("R3 displacing win", 0, 0, 0, 1, 24'h77, 8'd2);
    step("R4 offer blocked by op", 1, 2'd0, 0, 1, 24'h99, 8'd0);
    step("R6 IPI displaces", 1, 2'd2, 32'h01, 0, 0, 0);
    step("R7 IPI relaxed", 1, 2'd2, 32'h04, 0, 0, 0);
    step("R5 accept IPI", 1, 2'd0, 0, 0, 0, 0);
    step("R5 accept empty", 1, 2'd0, 0, 0, 0, 0);
    step("R3 top priority win", 0, 0, 0, 1, 24'h88, 8'd0);
    step("R9 tighten rejects", 1, 2'd1, 32'h00, 0, 0, 0);
    step("R8 equal threshold", 1, 2'd1, 32'h00, 0, 0, 0);
    step("R10 eoi of IPI", 1, 2'd3, 32'h0600_0002, 0, 0, 0);
    step("R11 IPI reject hidden", 1, 2'd1, 32'h03, 0, 0, 0);
    step("R10 eoi forwarded", 1, 2'd3, 32'hFF00_0123, 0, 0, 0);

    for (int i = 0; i < 4000; i++) begin
      bit          opv;
      logic [1:0]  k;
      logic [23:0] s;
      opv = ($urandom % 3 == 0);
      k   = 2'($urandom % 4);
      s   = ($urandom % 4 == 0) ? IPI : 24'(3 + $urandom % 500);
      step("random", opv, k, {rnd_prio(), s[23:8], rnd_prio()} & (k == 2'd3 ? 32'hFF00_0000 : 32'h0000_00FF) | (k == 2'd3 ? {8'h0, s} : 32'h0),
           ($urandom % 4 != 0), 24'(3 + $urandom % 500), rnd_prio());
    end

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule